// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block drives the periodic interrupt output of a real-time clock. It divides a 32.768 kHz oscillator tick down to one second and produces a seconds-increment strobe for an external calendar counter. A 3-bit mode field selects what the active-low interrupt pin does. It can stay inactive, be held low, carry a 2 Hz or 1 Hz square wave locked to the second boundary, or act as a latched flag. The latched flag fires once per second, minute, hour or month.

All logic runs on one system clock, and the oscillator arrives as a one-cycle enable. The external calendar supplies rollover indications for minute, hour and month. These are valid in the cycle the seconds strobe is high. A host write to the seconds counter clears the sub-second divider. The host clears a latched flag by writing it to zero.

The controller has five states:
- `ST_IDLE`: mode 000, pin high.
- `ST_HOLD`: mode 001, pin low.
- `ST_PULSE`: modes 010 and 011.
- `ST_ARMED`: level mode, waiting for an event.
- `ST_FIRED`: level mode, flag latched.

Its transitions are:
- `MODE_LOAD`: any mode write, into the state the new mode selects.
- `EVENT_HIT`: `ST_ARMED` to `ST_FIRED`.
- `HOST_CLEAR`: `ST_FIRED` to `ST_ARMED`.

Top module: `rtc_pint_gen`

## Requirements
- R1: After reset the mode is 010 (2 Hz pulse) and the divider is zero, so `int_n`=0, `int_flag`=1 and `sec_inc`=0.
- R2: In mode 000, `int_n` is 1 and `int_flag` is 0.
- R3: In mode 001, `int_n` is 0 and `int_flag` is 0.
- R4: In mode 010, `int_n` equals divider bit DIV_W-2. The pin is low for the first quarter-second of each half second, a 50% duty 2 Hz wave.
- R5: In mode 011, `int_n` equals divider bit DIV_W-1. The pin is low for the first half of each second, a 50% duty 1 Hz wave.
- R6: `sec_inc` is a one-cycle pulse. It is high in the cycle after the INC_DLY-th tick that follows the tick which wrapped the divider to zero.
- R7: Mode 100 treats every `sec_inc` as an event. Modes 101, 110 and 111 treat `sec_inc` together with `min_roll`, `hour_roll` or `month_roll` respectively as an event. An event sets `int_flag`=1 and `int_n`=0 from the next cycle.
- R8: A latched level flag and the low pin stay until a `flag_clr` cycle with no event. After that cycle `int_flag`=0 and `int_n`=1.
- R9: When `flag_clr` and an event fall in the same cycle, the flag stays set.
- R10: A mode write takes effect in the next cycle and clears any latched flag. A level mode restarts armed, with the pin high.
- R11: `sec_wr` clears the divider and the pending delay, and suppresses `sec_inc` in the next cycle. In pulse modes the pin is low from the next cycle.
- R12: In pulse modes `int_flag` is the inverse of `int_n`. In modes 000 and 001 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | New mode value |
| flag_clr | input | 1 | Host writes the interrupt flag to 0 |
| sec_wr | input | 1 | Host write to the seconds counter |
| min_roll | input | 1 | Increment brings seconds to 00 (valid with `sec_inc`) |
| hour_roll | input | 1 | Increment brings minutes and seconds to 00 |
| month_roll | input | 1 | Increment reaches 00:00:00 on day one of a month |
| int_n | output | 1 | Active-low interrupt pin |
| int_flag | output | 1 | Readable interrupt flag |
| sec_inc | output | 1 | Seconds-increment strobe to the calendar |

## Verification
The pulse-mode pin follows a divider register, so it changes in the cycle after the tick that moves that divider bit. `sec_inc` is registered, so it is high one cycle after the INC_DLY-th post-wrap tick. The level flag and pin react one cycle after the `sec_inc` cycle that carries an event. Mode writes, flag clears and seconds writes show their effect one cycle after the strobe. The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. It then compares all three outputs at the next falling edge against a bench model advanced by the same rising edge, so every result is sampled in the cycle it is due.

// File: rtl/rtc_pint_pkg.sv
package rtc_pint_pkg;

    typedef enum logic [2:0] {
        MD_OFF  = 3'b000,
        MD_LOW  = 3'b001,
        MD_P2HZ = 3'b010,
        MD_P1HZ = 3'b011,
        MD_LSEC = 3'b100,
        MD_LMIN = 3'b101,
        MD_LHR  = 3'b110,
        MD_LMON = 3'b111
    } pint_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_PULSE,
        ST_ARMED,
        ST_FIRED
    } pint_state_e;

    localparam pint_mode_e RST_MODE = MD_P2HZ;

    function automatic pint_state_e entry_state(input pint_mode_e md);
        pint_state_e s;
        unique case (md)
            MD_OFF:           s = ST_IDLE;
            MD_LOW:           s = ST_HOLD;
            MD_P2HZ, MD_P1HZ: s = ST_PULSE;
            default:          s = ST_ARMED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rtc_pint_div.sv
module rtc_pint_div #(
    parameter int DIV_W   = 15,
    parameter int INC_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic sec_wr,
    output logic half_ph,
    output logic sec_ph,
    output logic sec_inc
);
    localparam int DLY_W = $clog2(INC_DLY + 1);

    logic [DIV_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q;
    logic             inc_q;
    logic             wrap;

    assign wrap = &cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dly_q <= '0;
            inc_q <= 1'b0;
        end else if (sec_wr) begin
            cnt_q <= '0;
            dly_q <= '0;
            inc_q <= 1'b0;
        end else begin
            inc_q <= tick_en && (dly_q == DLY_W'(1));
            if (tick_en) begin
                cnt_q <= cnt_q + 1'b1;
                if (wrap)
                    dly_q <= DLY_W'(INC_DLY);
                else if (dly_q != '0)
                    dly_q <= dly_q - 1'b1;
            end
        end
    end

    assign half_ph = cnt_q[DIV_W-2];
    assign sec_ph  = cnt_q[DIV_W-1];
    assign sec_inc = inc_q;
endmodule

// File: rtl/rtc_pint_ctl.sv
module rtc_pint_ctl
    import rtc_pint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       flag_clr,
    input  logic       sec_inc,
    input  logic       min_roll,
    input  logic       hour_roll,
    input  logic       month_roll,
    input  logic       half_ph,
    input  logic       sec_ph,
    output logic       int_n,
    output logic       int_flag,
    output logic [2:0] mode_q
);
    pint_mode_e  mode_r;
    pint_state_e state_q, state_d;
    logic        ev;

    always_comb begin
        unique case (mode_r)
            MD_LSEC: ev = sec_inc;
            MD_LMIN: ev = sec_inc && min_roll;
            MD_LHR:  ev = sec_inc && hour_roll;
            MD_LMON: ev = sec_inc && month_roll;
            default: ev = 1'b0;
        endcase
    end

    // next state: MODE_LOAD, EVENT_HIT, HOST_CLEAR
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = entry_state(pint_mode_e'(mode_wdata));
        end else begin
            unique case (state_q)
                ST_ARMED: if (ev) state_d = ST_FIRED;
                ST_FIRED: if (flag_clr && !ev) state_d = ST_ARMED;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PULSE;
            mode_r  <= RST_MODE;
        end else begin
            state_q <= state_d;
            if (mode_wr)
                mode_r <= pint_mode_e'(mode_wdata);
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  begin int_n = 1'b1; int_flag = 1'b0; end
            ST_HOLD:  begin int_n = 1'b0; int_flag = 1'b0; end
            ST_PULSE: begin
                int_n    = (mode_r == MD_P1HZ) ? sec_ph : half_ph;
                int_flag = !int_n;
            end
            ST_ARMED: begin int_n = 1'b1; int_flag = 1'b0; end
            ST_FIRED: begin int_n = 1'b0; int_flag = 1'b1; end
            default:  begin int_n = 1'b1; int_flag = 1'b0; end
        endcase
    end

    assign mode_q = mode_r;
endmodule

// File: rtl/rtc_pint_gen.sv
module rtc_pint_gen #(
    parameter int DIV_W   = 15,
    parameter int INC_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       flag_clr,
    input  logic       sec_wr,
    input  logic       min_roll,
    input  logic       hour_roll,
    input  logic       month_roll,
    output logic       int_n,
    output logic       int_flag,
    output logic       sec_inc
);
    logic       half_ph;
    logic       sec_ph;
    logic [2:0] mode_q;

    rtc_pint_div #(.DIV_W(DIV_W), .INC_DLY(INC_DLY)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .sec_wr  (sec_wr),
        .half_ph (half_ph),
        .sec_ph  (sec_ph),
        .sec_inc (sec_inc)
    );

    rtc_pint_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .flag_clr   (flag_clr),
        .sec_inc    (sec_inc),
        .min_roll   (min_roll),
        .hour_roll  (hour_roll),
        .month_roll (month_roll),
        .half_ph    (half_ph),
        .sec_ph     (sec_ph),
        .int_n      (int_n),
        .int_flag   (int_flag),
        .mode_q     (mode_q)
    );
endmodule

// File: rtl/rtc_pint_gen_chk.sv
module rtc_pint_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic [2:0] mode_wdata,
    input logic       flag_clr,
    input logic       sec_wr,
    input logic       int_n,
    input logic       int_flag,
    input logic       sec_inc,
    input logic [2:0] mode_q
);
    AST_INC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sec_inc |=> !sec_inc); // R6
    AST_SECWR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n) sec_wr |=> !sec_inc); // R11
    AST_SECWR_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sec_wr && !mode_wr && mode_q[2:1] == 2'b01) |=> !int_n); // R11
    AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n) (mode_wr && mode_wdata == 3'b000) |=> (int_n && !int_flag)); // R2
    AST_LOW_MODE: assert property (@(posedge clk) disable iff (!rst_n) (mode_wr && mode_wdata == 3'b001) |=> (!int_n && !int_flag)); // R3
    AST_SEC_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'b100 && sec_inc && !mode_wr) |=> (!int_n && int_flag)); // R7
    AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'b100 && flag_clr && !sec_inc && !mode_wr) |=> (int_n && !int_flag)); // R8
    AST_MODE_REARM: assert property (@(posedge clk) disable iff (!rst_n) (mode_wr && mode_wdata[2]) |=> (int_n && !int_flag)); // R10
endmodule

bind rtc_pint_gen rtc_pint_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .flag_clr   (flag_clr),
    .sec_wr     (sec_wr),
    .int_n      (int_n),
    .int_flag   (int_flag),
    .sec_inc    (sec_inc),
    .mode_q     (mode_q)
);

// File: tb/sim_rtc_pint_gen.sv
`timescale 1ns/1ps
module sim_rtc_pint_gen;
    localparam int DW  = 6;
    localparam int N   = 1 << DW;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, mode_wr = 1'b0, flag_clr = 1'b0, sec_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic min_roll = 1'b0, hour_roll = 1'b0, month_roll = 1'b0;
    logic int_n, int_flag, sec_inc;

    int n_chk = 0;
    int n_fail = 0;

    logic [2:0] m_mode;
    logic       m_fired, m_inc;
    int         m_cnt, m_dly;

    always #2 clk = ~clk;

    rtc_pint_gen #(.DIV_W(DW), .INC_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .flag_clr(flag_clr), .sec_wr(sec_wr),
        .min_roll(min_roll), .hour_roll(hour_roll), .month_roll(month_roll),
        .int_n(int_n), .int_flag(int_flag), .sec_inc(sec_inc)
    );

    function automatic logic lvl_event(input logic [2:0] md, input logic inc);
        case (md)
            3'b100:  return inc;
            3'b101:  return inc && min_roll;
            3'b110:  return inc && hour_roll;
            3'b111:  return inc && month_roll;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_pin(input logic [2:0] md, input logic fired, input int cnt);
        case (md)
            3'b000:  return 1'b1;
            3'b001:  return 1'b0;
            3'b010:  return ((cnt / (N / 4)) % 2) != 0;
            3'b011:  return cnt >= N / 2;
            default: return !fired;
        endcase
    endfunction

    function automatic logic exp_flag(input logic [2:0] md, input logic fired, input int cnt);
        if (md[2]) return fired;
        if (md[1]) return !exp_pin(md, fired, cnt);
        return 1'b0;
    endfunction

    // bench reference model, advanced on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        logic ev;
        if (!rst_n) begin
            m_mode = 3'b010; m_fired = 1'b0; m_cnt = 0; m_dly = 0; m_inc = 1'b0;
        end else begin
            ev = lvl_event(m_mode, m_inc);
            if (mode_wr) begin
                m_mode = mode_wdata; m_fired = 1'b0;
            end else if (m_mode[2]) begin
                if (ev) m_fired = 1'b1;
                else if (flag_clr) m_fired = 1'b0;
            end
            if (sec_wr) begin
                m_cnt = 0; m_dly = 0; m_inc = 1'b0;
            end else begin
                m_inc = tick_en && (m_dly == 1);
                if (tick_en) begin
                    if (m_cnt == N - 1) begin m_cnt = 0; m_dly = DLY; end
                    else begin m_cnt = m_cnt + 1; if (m_dly != 0) m_dly = m_dly - 1; end
                end
            end
        end
    end

    task automatic cmp(input string tag);
        logic [2:0] a, e;
        a = {int_n, int_flag, sec_inc};
        e = {exp_pin(m_mode, m_fired, m_cnt), exp_flag(m_mode, m_fired, m_cnt), m_inc};
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: {int_n,int_flag,sec_inc} actual %b expected %b (mode %b)", tag, a, e, m_mode);
        end
    endtask

    function automatic string auto_tag();
        if (sec_inc !== m_inc) return "R6";
        case (m_mode)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        cmp(tag);
        mode_wr = 1'b0; sec_wr = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        cmp("R1");
        rst_n = 1'b1;
        cyc("R1");

        // R11: seconds write then a full second of 2 Hz, then the delayed strobe
        tick_en = 1'b1; repeat (10) cyc("R4");
        sec_wr = 1'b1; cyc("R11");
        for (int i = 0; i < N; i++) cyc("R4");
        for (int i = 0; i < DLY + 1; i++) cyc("R6");
        tick_en = 1'b0; cyc("R6");
        tick_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc("R12");
            n_chk++;
            if (int_flag !== !int_n) begin
                n_fail++;
                $display("FAIL R12: int_flag actual %b expected %b", int_flag, !int_n);
            end
        end

        mode_wr = 1'b1; mode_wdata = 3'b011; cyc("R10");
        for (int i = 0; i < N; i++) cyc("R5");
        mode_wr = 1'b1; mode_wdata = 3'b000; cyc("R2");
        repeat (5) cyc("R2");
        mode_wr = 1'b1; mode_wdata = 3'b001; cyc("R3");
        repeat (5) cyc("R3");

        // R7 / R8: per-second level flag
        mode_wr = 1'b1; mode_wdata = 3'b100; cyc("R10");
        for (int i = 0; i < 3 * N && !m_fired; i++) cyc("R7");
        repeat (5) cyc("R8");
        flag_clr = !m_inc; cyc("R8");
        cyc("R8");

        // R9: clear collides with a minute event
        mode_wr = 1'b1; mode_wdata = 3'b101; min_roll = 1'b1; cyc("R10");
        for (int i = 0; i < 3 * N && !m_fired; i++) cyc("R7");
        for (int i = 0; i < 3 * N; i++) begin
            if (m_inc) begin
                flag_clr = 1'b1; cyc("R9");
                n_chk++;
                if (int_flag !== 1'b1) begin
                    n_fail++;
                    $display("FAIL R9: int_flag actual %b expected 1", int_flag);
                end
                break;
            end
            cyc("R8");
        end
        min_roll = 1'b0;
        mode_wr = 1'b1; mode_wdata = 3'b110; cyc("R10");

        // constrained random phase
        for (int i = 0; i < 60000; i++) begin
            tick_en    = ($urandom % 4) != 0;
            mode_wr    = ($urandom % 400) == 0;
            mode_wdata = 3'($urandom);
            flag_clr   = ($urandom % 20) == 0;
            sec_wr     = ($urandom % 3000) == 0;
            min_roll   = ($urandom % 3) == 0;
            hour_roll  = ($urandom % 4) == 0;
            month_roll = ($urandom % 5) == 0;
            @(posedge clk);
            @(negedge clk);
            cmp(auto_tag());
        end
        summary();
        $finish;
    end
endmodule